// File: doc/BRIEF.md
# Set-Dueling Insertion Policy Controller

This block manages the replacement order of a set-associative cache. It does not store tags or data. For every set it keeps an age value per way, where age 0 is the most recently used way and age `WAYS-1` is the least recently used. When the cache misses, the block names the way to evict. When the cache hits, it promotes the way that hit. When the cache fills a way, it places the new line either at the head or at the tail of the recency order.

The insertion position of a fill depends on the kind of set being filled:

- A few *head leader* sets always insert at the head.
- A few *bimodal leader* sets insert at the tail, except for a pseudo-random one fill in 32, which goes to the head.
- Every other set is a *follower*. A follower uses whichever of the two leader policies is currently missing less.

A 10-bit saturating selector decides which policy that is. Misses in head leaders push the selector up, and misses in bimodal leaders pull it down. Followers use the bimodal policy while the selector's top bit is 1.

The cache pipeline issues one request per cycle. Each request carries an operation, a set index and a way. The results appear on the registered outputs one cycle later.

Top module: `dip_ctrl`

## Requirements
- R1: After reset, way w of every set has age w, the selector holds 512 (so followers are bimodal), and the random generator holds 0xACE1. No output valid is asserted while reset is active.
- R2: An operation code of 1 (miss) asserts `victim_valid` in the next cycle. `victim_way` then names the way of that set whose age is `WAYS-1`. A miss leaves the ages unchanged.
- R3: An operation code of 0 (hit) on way w sets w's age to 0 and adds 1 to every way younger than w. Older ways keep their ages. The new ages of the set appear on `upd_ages` next cycle with `upd_valid`, where way w's age is in bits [w*AGE_W +: AGE_W].
- R4: An operation code of 2 (fill) inserted at the head changes the ages in the same way as a hit on the filled way. The result is reported the same way as in R3.
- R5: A fill inserted at the tail gives the filled way age `WAYS-1`, and every way older than its previous age loses 1.
- R6: A set whose index has its low `LEAD_W` bits all zero is a head leader, and every fill there is inserted at the head. A set whose low `LEAD_W` bits are all one is a bimodal leader.
- R7: A bimodal decision inserts at the head only when the low 5 bits of the 16-bit generator are zero. Otherwise it inserts at the tail. The generator shifts left once per fill in any set, taking the XOR of bits 15, 13, 12 and 10 into bit 0. The decision uses the value before the shift.
- R8: A miss in a head leader adds 1 to the selector, saturating at 1023. A miss in a bimodal leader subtracts 1, saturating at 0. A miss in a follower leaves the selector unchanged.
- R9: A fill in a follower set uses the bimodal decision of R7 when selector bit 9 is 1, and inserts at the head when it is 0.
- R10: Requests may arrive in consecutive cycles to the same set. Each one sees the ages left by the one before it. `victim_valid` and `upd_valid` are never high together.
- R11: Operation code 3 produces no output and changes no ages, selector or generator state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 hit, 1 miss, 2 fill, 3 no operation |
| req_set | input | $clog2(SETS) | Set index |
| req_way | input | $clog2(WAYS) | Hit way or filled way |
| victim_valid | output | 1 | Victim result for the previous miss |
| victim_way | output | $clog2(WAYS) | Least recently used way of the missing set |
| upd_valid | output | 1 | Updated ages for the previous hit or fill |
| upd_ages | output | WAYS*$clog2(WAYS) | New age of every way of that set |

## Verification
The bench drives long runs of leader misses to reach both ends of the selector. A counter that wraps instead of saturating would flip the followers' policy, and the follower fills would then land at the wrong end.

Fills into ways that are not already at the tail show the difference between head and tail insertion. A swapped leader classification, or a bimodal decision taken after the generator shifts, therefore shows up as a wrong age vector.

Back-to-back hits to one set, and a no-op placed between a hit and a miss, expose a stale read of the age storage and a no-op that leaks state.

// File: rtl/dip_pkg.sv
package dip_pkg;

    typedef enum logic [1:0] {
        OP_HIT  = 2'd0,
        OP_MISS = 2'd1,
        OP_FILL = 2'd2,
        OP_NONE = 2'd3
    } dip_op_e;

    typedef enum logic [1:0] {
        AGE_HOLD,
        AGE_TO_HEAD,
        AGE_TO_TAIL
    } age_move_e;

    typedef enum logic [1:0] {
        ROLE_FOLLOWER,
        ROLE_LEAD_HEAD,
        ROLE_LEAD_BIMODAL
    } set_role_e;

endpackage

// File: rtl/dip_lfsr.sv
module dip_lfsr #(
    parameter int          W     = 16,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter int          CMP_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic low_zero
);
    logic [W-1:0] s_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= SEED;
        end else if (step) begin
            s_q <= {s_q[W-2:0], ^(s_q & TAPS)};
        end
    end

    assign low_zero = (s_q[CMP_W-1:0] == '0);
endmodule

// File: rtl/dip_psel.sv
module dip_psel #(
    parameter int W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up,
    input  logic down,
    output logic top_bit
);
    localparam logic [W-1:0] MID = 1 << (W - 1);
    localparam logic [W-1:0] MAX = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= MID;
        end else if (up && cnt_q != MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (down && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign top_bit = cnt_q[W-1];
endmodule

// File: rtl/dip_recency.sv
module dip_recency
    import dip_pkg::*;
#(
    parameter int SETS = 64,
    parameter int WAYS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [$clog2(SETS)-1:0]              set_idx,
    input  logic [$clog2(WAYS)-1:0]              way_idx,
    input  age_move_e                            move,
    output logic [WAYS*$clog2(WAYS)-1:0]         nxt_ages,
    output logic [$clog2(WAYS)-1:0]              victim
);
    localparam int AGE_W = $clog2(WAYS);
    localparam int ROW_W = WAYS * AGE_W;
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

    function automatic logic [ROW_W-1:0] init_row();
        logic [ROW_W-1:0] r;
        for (int w = 0; w < WAYS; w++) begin
            r[w*AGE_W +: AGE_W] = AGE_W'(w);
        end
        return r;
    endfunction

    logic [ROW_W-1:0] age_q [SETS];
    logic [ROW_W-1:0] cur;
    logic [AGE_W-1:0] pivot;

    always_comb begin
        cur      = age_q[set_idx];
        pivot    = cur[way_idx*AGE_W +: AGE_W];
        nxt_ages = cur;
        victim   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (cur[w*AGE_W +: AGE_W] == OLDEST) begin
                victim = AGE_W'(w);
            end
            unique case (move)
                AGE_TO_HEAD: begin
                    if (w == int'(way_idx)) begin
                        nxt_ages[w*AGE_W +: AGE_W] = '0;
                    end else if (cur[w*AGE_W +: AGE_W] < pivot) begin
                        nxt_ages[w*AGE_W +: AGE_W] = cur[w*AGE_W +: AGE_W] + 1'b1;
                    end
                end
                AGE_TO_TAIL: begin
                    if (w == int'(way_idx)) begin
                        nxt_ages[w*AGE_W +: AGE_W] = OLDEST;
                    end else if (cur[w*AGE_W +: AGE_W] > pivot) begin
                        nxt_ages[w*AGE_W +: AGE_W] = cur[w*AGE_W +: AGE_W] - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                age_q[s] <= init_row();
            end
        end else if (move != AGE_HOLD) begin
            age_q[set_idx] <= nxt_ages;
        end
    end
endmodule

// File: rtl/dip_ctrl.sv
module dip_ctrl
    import dip_pkg::*;
#(
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    parameter int LEAD_W = 4,
    parameter int PSEL_W = 10,
    parameter int RNG_W  = 16,
    parameter int BIP_W  = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    input  logic [1:0]                       req_op,
    input  logic [$clog2(SETS)-1:0]          req_set,
    input  logic [$clog2(WAYS)-1:0]          req_way,
    output logic                             victim_valid,
    output logic [$clog2(WAYS)-1:0]          victim_way,
    output logic                             upd_valid,
    output logic [WAYS*$clog2(WAYS)-1:0]     upd_ages
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int ROW_W = WAYS * WAY_W;

    dip_op_e          op;
    set_role_e        role;
    age_move_e        move;
    logic             psel_top;
    logic             rng_low_zero;
    logic             bimodal_head;
    logic             fill_head;
    logic [ROW_W-1:0] nxt_ages;
    logic [WAY_W-1:0] lru_way;

    assign op = dip_op_e'(req_op);

    always_comb begin
        if (req_set[LEAD_W-1:0] == '0) begin
            role = ROLE_LEAD_HEAD;
        end else if (&req_set[LEAD_W-1:0]) begin
            role = ROLE_LEAD_BIMODAL;
        end else begin
            role = ROLE_FOLLOWER;
        end
    end

    assign bimodal_head = rng_low_zero;

    always_comb begin
        unique case (role)
            ROLE_LEAD_HEAD:    fill_head = 1'b1;
            ROLE_LEAD_BIMODAL: fill_head = bimodal_head;
            default:           fill_head = psel_top ? bimodal_head : 1'b1;
        endcase
    end

    always_comb begin
        move = AGE_HOLD;
        if (req_valid) begin
            unique case (op)
                OP_HIT:  move = AGE_TO_HEAD;
                OP_FILL: move = fill_head ? AGE_TO_HEAD : AGE_TO_TAIL;
                OP_MISS: move = AGE_HOLD;
                OP_NONE: move = AGE_HOLD;
            endcase
        end
    end

    dip_recency #(.SETS(SETS), .WAYS(WAYS)) u_recency (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_idx  (req_set),
        .way_idx  (req_way),
        .move     (move),
        .nxt_ages (nxt_ages),
        .victim   (lru_way)
    );

    dip_psel #(.W(PSEL_W)) u_psel (
        .clk     (clk),
        .rst_n   (rst_n),
        .up      (req_valid && op == OP_MISS && role == ROLE_LEAD_HEAD),
        .down    (req_valid && op == OP_MISS && role == ROLE_LEAD_BIMODAL),
        .top_bit (psel_top)
    );

    dip_lfsr #(.W(RNG_W), .CMP_W(BIP_W)) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (req_valid && op == OP_FILL),
        .low_zero (rng_low_zero)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_valid <= 1'b0;
            victim_way   <= '0;
            upd_valid    <= 1'b0;
            upd_ages     <= '0;
        end else begin
            victim_valid <= 1'b0;
            upd_valid    <= 1'b0;
            if (req_valid) begin
                unique case (op)
                    OP_HIT, OP_FILL: begin
                        upd_valid <= 1'b1;
                        upd_ages  <= nxt_ages;
                    end
                    OP_MISS: begin
                        victim_valid <= 1'b1;
                        victim_way   <= lru_way;
                    end
                    OP_NONE: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dip_ctrl_chk.sv
module dip_ctrl_chk #(
    parameter int WAYS   = 4,
    parameter int SET_W  = 6,
    parameter int LEAD_W = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            req_valid,
    input logic [1:0]                      req_op,
    input logic [SET_W-1:0]                req_set,
    input logic [$clog2(WAYS)-1:0]         req_way,
    input logic                            victim_valid,
    input logic                            upd_valid,
    input logic [WAYS*$clog2(WAYS)-1:0]    upd_ages
);
    localparam int AGE_W = $clog2(WAYS);

    function automatic logic [AGE_W-1:0] age_of(logic [WAYS*AGE_W-1:0] v,
                                                logic [AGE_W-1:0] w);
        return v[w*AGE_W +: AGE_W];
    endfunction

    function automatic logic distinct(logic [WAYS*AGE_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int a = 0; a < WAYS; a++) begin
            for (int b = a + 1; b < WAYS; b++) begin
                if (v[a*AGE_W +: AGE_W] == v[b*AGE_W +: AGE_W]) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    assert_miss_reports_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1) |=> (victim_valid && !upd_valid));

    assert_hit_to_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0) |=> (upd_valid && age_of(upd_ages, $past(req_way)) == '0));

    assert_ages_distinct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> distinct(upd_ages));

    assert_head_leader_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2 && req_set[LEAD_W-1:0] == '0)
        |=> (upd_valid && age_of(upd_ages, $past(req_way)) == '0));

    assert_outputs_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(victim_valid && upd_valid));
endmodule

bind dip_ctrl dip_ctrl_chk #(.WAYS(WAYS), .SET_W(SET_W), .LEAD_W(LEAD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_set      (req_set),
    .req_way      (req_way),
    .victim_valid (victim_valid),
    .upd_valid    (upd_valid),
    .upd_ages     (upd_ages)
);

// File: tb/tb_dip_ctrl.sv
`timescale 1ns/1ps
module tb_dip_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 64;
    localparam int WAYS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [5:0] req_set = '0;
    logic [1:0] req_way = '0;
    logic       victim_valid;
    logic [1:0] victim_way;
    logic       upd_valid;
    logic [7:0] upd_ages;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dip_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_set(req_set), .req_way(req_way), .victim_valid(victim_valid),
        .victim_way(victim_way), .upd_valid(upd_valid), .upd_ages(upd_ages)
    );

    typedef struct {
        bit         is_victim;
        logic [1:0] victim;
        logic [7:0] ages;
        int         req;
    } exp_t;

    exp_t        sb[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 0;
    int          m_age [SETS][WAYS];
    int          m_psel;
    logic [15:0] m_rng;

    task automatic check(bit ok, int req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int role_of(int s);
        if ((s & 15) == 0) return 1;
        if ((s & 15) == 15) return 2;
        return 0;
    endfunction

    function automatic logic [7:0] pack_row(int s);
        logic [7:0] r;
        for (int w = 0; w < WAYS; w++) r[w*2 +: 2] = 2'(m_age[s][w]);
        return r;
    endfunction

    function automatic void move_row(int s, int w, bit head);
        int p;
        p = m_age[s][w];
        for (int x = 0; x < WAYS; x++) begin
            if (x == w) m_age[s][x] = head ? 0 : WAYS - 1;
            else if (head && m_age[s][x] < p) m_age[s][x]++;
            else if (!head && m_age[s][x] > p) m_age[s][x]--;
        end
    endfunction

    // Driver: drives one request per cycle and pushes what the outputs must show.
    task automatic do_req(int op, int s, int w, int req);
        exp_t e;
        bit   head;
        bit   bim;
        @(negedge clk);
        req_valid = 1'b1;
        req_op = 2'(op);
        req_set = 6'(s);
        req_way = 2'(w);
        e.req = req;
        e.ages = '0;
        e.victim = '0;
        case (op)
            0: begin                                    // R3
                move_row(s, w, 1'b1);
                e.is_victim = 1'b0;
                e.ages = pack_row(s);
                sb.push_back(e);
            end
            1: begin                                    // R2, R8
                e.is_victim = 1'b1;
                for (int x = 0; x < WAYS; x++) if (m_age[s][x] == WAYS - 1) e.victim = 2'(x);
                if (role_of(s) == 1 && m_psel < 1023) m_psel++;
                if (role_of(s) == 2 && m_psel > 0) m_psel--;
                sb.push_back(e);
            end
            2: begin                                    // R4..R7, R9
                bim = (m_rng[4:0] == 5'd0);
                if (role_of(s) == 1) head = 1'b1;
                else if (role_of(s) == 2) head = bim;
                else head = (m_psel >= 512) ? bim : 1'b1;
                m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
                move_row(s, w, head);
                e.is_victim = 1'b0;
                e.ages = pack_row(s);
                sb.push_back(e);
            end
            default: ;                                  // R11: nothing expected
        endcase
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // Monitor: pops expected items as results appear.
    always @(negedge clk) begin
        if (rst_n && !done && (victim_valid || upd_valid)) begin
            if (sb.size() == 0) begin
                check(1'b0, 10, "unexpected output", {victim_valid, upd_valid}, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_victim) begin
                    check(victim_valid && !upd_valid, 10, "victim strobe",
                          {victim_valid, upd_valid}, 2'b10);
                    check(victim_way == e.victim, e.req, "victim way", victim_way, e.victim);
                end else begin
                    check(upd_valid && !victim_valid, 10, "update strobe",
                          {victim_valid, upd_valid}, 2'b01);
                    check(upd_ages == e.ages, e.req, "ages", upd_ages, e.ages);
                end
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        done = 1;
        check(1'b0, 10, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_age[s][w] = w;
        m_psel = 512;
        m_rng = 16'hACE1;
        repeat (3) @(negedge clk);
        // R1: no strobes during reset
        check(!victim_valid && !upd_valid, 1, "reset strobes", {victim_valid, upd_valid}, 0);
        rst_n = 1'b1;

        // R1, R2: reset order gives way 3 as LRU
        do_req(1, 5, 0, 1);
        do_req(1, 0, 0, 1);
        do_req(0, 5, 2, 3);                 // R3
        do_req(1, 5, 0, 2);                 // R2: miss leaves ages unchanged
        do_req(0, 5, 3, 3);
        do_req(1, 5, 0, 2);
        do_req(1, 5, 0, 2);
        // R6: head leader fills
        for (int i = 0; i < 8; i++) do_req(2, 0, (i * 3) % 4, 6);
        // R5, R9: follower fill while selector top bit is 1
        do_req(2, 5, 1, 9);
        // R7: bimodal leader over many generator steps
        for (int i = 0; i < 80; i++) do_req(2, 15, i % 4, 7);
        // R11: no-op between a hit and a miss
        do_req(0, 5, 0, 3);
        do_req(3, 5, 2, 11);
        do_req(1, 5, 0, 11);
        do_req(0, 5, 0, 11);

        // R8: saturate high, follower misses have no effect
        for (int i = 0; i < 600; i++) do_req(1, 16, 0, 8);
        for (int i = 0; i < 20; i++) do_req(1, 7, 0, 8);
        for (int i = 0; i < 40; i++) do_req(2, 9, i % 4, 9);
        for (int i = 0; i < 511; i++) do_req(1, 31, 0, 8);
        for (int i = 0; i < 8; i++) do_req(2, 9, (i + 1) % 4, 9);  // R9: still bimodal
        do_req(1, 31, 0, 8);
        for (int i = 0; i < 8; i++) do_req(2, 9, (i + 2) % 4, 9);  // R9: now head
        // R8: saturate low
        for (int i = 0; i < 1100; i++) do_req(1, 47, 0, 8);
        for (int i = 0; i < 10; i++) do_req(2, 9, i % 4, 9);
        for (int i = 0; i < 512; i++) do_req(1, 32, 0, 8);
        for (int i = 0; i < 40; i++) do_req(2, 9, (i + 3) % 4, 5);  // R5 via bimodal tail fills

        // R10: back-to-back requests to one set
        do_req(0, 20, 1, 10);
        do_req(0, 20, 3, 10);
        do_req(0, 20, 1, 10);
        do_req(1, 20, 0, 10);
        do_req(2, 20, 2, 10);
        do_req(1, 20, 0, 10);

        repeat (3) @(negedge clk);
        check(sb.size() == 0, 10, "results missing", sb.size(), 0);
        done = 1;
        finish_run();
    end
endmodule